// File: doc/BRIEF.md
# Window Watchdog Timer

This block is a watchdog for a power-management device. Software sets it up through a small register bus (write enable, address, write data and combinational read data) and services it by writing a feed register. A 1 µs tick input sets the timebase. Two limits come from the timeout register. The short limit doubles from a base of 3370 ticks, and the long limit is a power-of-two multiple of the short limit.

In slow mode only a missing feed counts as a fault, which happens when the count reaches the long limit. Window mode adds a second fault: a feed that arrives before the short limit has elapsed. Every fault sets a sticky status flag that drives the interrupt output. When the configuration selects the reset action, a fault also produces a fixed-length pulse on the reset output. After every fault, and after every accepted feed, the count starts again from zero.

Top module: `wdog_window_top`

## Requirements
- R1: After reset every register reads 0, and `irq` and `rst_out` are low. The configuration register (address 0) reads back its bits 3:0, with bits 7:4 reading 0. The timeout register (address 1) reads back bits 6:4 and 1:0, with all other bits 0. The feed register (address 2) always reads 0.
- R2: The short limit is 3370 << sel ticks, where sel is timeout bits 6:4. The long limit is short << (ratio+1) ticks, where ratio is timeout bits 1:0.
- R3: The configuration register has four fields. Bits 1:0 are the enable field, and only the value 01 runs the watchdog. Bit 2 selects the mode: 1 is slow mode and 0 is window mode. Bit 3 selects the action: 1 is reset plus interrupt and 0 is interrupt only. With the enable field at 00, 10 or 11 the block never counts, never faults, and ignores feeds.
- R4: While the watchdog is not enabled, the count is held at zero. While enabled, the count advances by one only in cycles where `tick_us` is high.
- R5: In both modes, a count that reaches the long limit is a fault. The status flag sets on the clock edge after the count reaches the long limit, and the count restarts from zero.
- R6: In window mode, a feed while the count is below the short limit is a fault, and the status flag sets on the edge of the feed write. A feed at a count of at least the short limit is accepted. In slow mode, every feed below the long limit is accepted.
- R7: A feed is a write to address 2 with data bit 0 set. An accepted feed restarts the count from zero. A write to address 2 with bit 0 clear has no effect.
- R8: The status flag reads at address 3 bit 0 and drives `irq`. It stays set until software writes address 3 with bit 0 set. A write with bit 0 clear leaves the flag unchanged.
- R9: With the action bit at 1, a fault drives `rst_out` high for exactly 16 cycles, starting at the edge on which the status flag sets. With the action bit at 0, `rst_out` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_us | input | 1 | One-cycle timebase strobe, one per microsecond |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Sticky fault interrupt |
| rst_out | output | 1 | Reset pulse on a fault when the action bit is 1 |

## Verification
The bench places feeds exactly one tick either side of the short limit in window mode. A design with an off-by-one comparison would either accept the early feed or flag the legal one. It measures how many cycles after enable and after a feed the late fault appears, with two timeout settings. A wrong shift in the limit arithmetic, or a count that does not restart, would move that edge. It also holds the tick low, uses the disabled enable encodings, and writes feeds and clears with bit 0 clear. A design that counted without a tick, or acted on those writes, would raise the interrupt when it should not. Finally it counts the cycles in the reset pulse, which catches a pulse that is one cycle too long or too short.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int REG_W = 8;
  localparam int ADR_W = 2;

  localparam logic [ADR_W-1:0] ADR_CFG  = 2'd0;
  localparam logic [ADR_W-1:0] ADR_TMO  = 2'd1;
  localparam logic [ADR_W-1:0] ADR_FEED = 2'd2;
  localparam logic [ADR_W-1:0] ADR_STAT = 2'd3;

  localparam logic [1:0] EN_RUN = 2'b01;

  typedef struct packed {
    logic       rst_act;
    logic       slow;
    logic [1:0] en;
  } cfg_t;

  typedef struct packed {
    logic [2:0] sel;
    logic [1:0] ratio;
  } tmo_t;

  function automatic logic [31:0] short_ticks(input int base, input logic [2:0] sel);
    logic [31:0] b;
    b = 32'(base);
    return b << sel;
  endfunction

  function automatic logic [31:0] long_ticks(input int base, input logic [2:0] sel,
                                             input logic [1:0] ratio);
    return short_ticks(base, sel) << (32'(ratio) + 32'd1);
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] addr,
  input  logic [REG_W-1:0] wdata,
  input  logic             fault,
  output cfg_t             cfg,
  output tmo_t             tmo,
  output logic             feed_req,
  output logic             clr_req,
  output logic             flag,
  output logic [REG_W-1:0] rdata
);

  logic wr_cfg, wr_tmo;

  assign wr_cfg   = wr_en && (addr == ADR_CFG);
  assign wr_tmo   = wr_en && (addr == ADR_TMO);
  assign feed_req = wr_en && (addr == ADR_FEED) && wdata[0];
  assign clr_req  = wr_en && (addr == ADR_STAT) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
      tmo <= '0;
    end else begin
      if (wr_cfg) cfg <= cfg_t'(wdata[3:0]);
      if (wr_tmo) tmo <= '{sel: wdata[6:4], ratio: wdata[1:0]};
    end
  end

  // set wins over clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (fault)   flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_CFG:  rdata[3:0] = cfg;
      ADR_TMO:  begin
        rdata[6:4] = tmo.sel;
        rdata[1:0] = tmo.ratio;
      end
      ADR_STAT: rdata[0] = flag;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int BASE_TICKS = 3370,
  parameter int CNT_W      = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             active,
  input  logic             slow,
  input  tmo_t             tmo,
  input  logic             feed_req,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] short_lim,
  output logic [CNT_W-1:0] long_lim,
  output logic             feed_ok,
  output logic             early_fault,
  output logic             late_fault,
  output logic             fault
);

  assign short_lim = CNT_W'(short_ticks(BASE_TICKS, tmo.sel));
  assign long_lim  = CNT_W'(long_ticks(BASE_TICKS, tmo.sel, tmo.ratio));

  assign late_fault  = active && (cnt >= long_lim);
  assign early_fault = active && feed_req && !slow && !late_fault && (cnt < short_lim);
  assign feed_ok     = active && feed_req && !late_fault && !early_fault;
  assign fault       = late_fault || early_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (!active || feed_ok || fault) cnt <= '0;
    else if (tick)                       cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int LEN = 16,
  localparam int PW = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pulse
);

  logic [PW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          left <= '0;
    else if (start)      left <= PW'(LEN);
    else if (left != '0) left <= left - 1'b1;
  end

  assign pulse = (left != '0);

endmodule

// File: rtl/wdog_window_top.sv
module wdog_window_top
  import wdog_pkg::*;
#(
  parameter int BASE_TICKS = 3370,
  parameter int RST_CYCLES = 16,
  localparam int MAX_TICKS = BASE_TICKS * 128 * 16,
  localparam int CNT_W     = $clog2(MAX_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_us,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             irq,
  output logic             rst_out
);

  cfg_t             cfg;
  tmo_t             tmo;
  logic             feed_req, clr_req, flag;
  logic             active;
  logic [CNT_W-1:0] cnt, short_lim, long_lim;
  logic             feed_ok, early_fault, late_fault, fault;

  assign active = (cfg.en == EN_RUN);

  wdog_regs i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .fault(fault), .cfg(cfg), .tmo(tmo), .feed_req(feed_req),
    .clr_req(clr_req), .flag(flag), .rdata(rdata)
  );

  wdog_timer #(.BASE_TICKS(BASE_TICKS), .CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_us), .active(active), .slow(cfg.slow),
    .tmo(tmo), .feed_req(feed_req), .cnt(cnt), .short_lim(short_lim),
    .long_lim(long_lim), .feed_ok(feed_ok), .early_fault(early_fault),
    .late_fault(late_fault), .fault(fault)
  );

  wdog_pulse #(.LEN(RST_CYCLES)) i_pulse (
    .clk(clk), .rst_n(rst_n), .start(fault && cfg.rst_act), .pulse(rst_out)
  );

  assign irq = flag;

endmodule

// File: rtl/wdog_window_chk.sv
module wdog_window_chk #(
  parameter int CNT_W = 23
) (
  input logic             clk,
  input logic             rst_n,
  input logic             active,
  input logic             slow,
  input logic             rst_act,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] long_lim,
  input logic             feed_ok,
  input logic             early_fault,
  input logic             clr_req,
  input logic             irq,
  input logic             rst_out
);

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> cnt == '0);

  a_r5_late_restart: assert property (@(posedge clk) disable iff (!rst_n)
    active && (cnt >= long_lim) |=> cnt == '0);

  a_r5_late_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    active && (cnt >= long_lim) |=> irq);

  a_r6_early_window_only: assert property (@(posedge clk) disable iff (!rst_n)
    early_fault |-> !slow);

  a_r7_feed_restart: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |=> cnt == '0);

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_req |=> irq);

  a_r9_rst_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> irq);

  a_r9_rst_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> $past(rst_act));

endmodule

bind wdog_window_top wdog_window_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .slow(cfg.slow),
  .rst_act(cfg.rst_act), .cnt(cnt), .long_lim(long_lim), .feed_ok(feed_ok),
  .early_fault(early_fault), .clr_req(clr_req), .irq(irq), .rst_out(rst_out)
);

// File: tb/test_wdog_window_top.sv
`timescale 1ns/100ps
module test_wdog_window_top;

  localparam int BASE = 3370;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_us = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, rst_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdog_window_top i_wdog_window_top (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rst_out(rst_out)
  );

  function automatic int t_short(int sel);
    return BASE * (2 ** sel);
  endfunction

  function automatic int t_long(int sel, int ratio);
    return t_short(sel) * (2 ** (ratio + 1));
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h01);
  endtask

  task automatic t_reset_state();
    int v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 reset reg", v, 0);
    end
    check("R1 reset irq", int'(irq), 0);
    check("R1 reset rst_out", int'(rst_out), 0);
  endtask

  task automatic t_readback();
    int v;
    wr(2'd0, 8'hFF);
    rd(2'd0, v);
    check("R1 cfg readback", v, 8'h0F);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hFF);
    rd(2'd1, v);
    check("R1 tmo readback", v, 8'h73);
    wr(2'd2, 8'hFF);
    rd(2'd2, v);
    check("R1 feed reads zero", v, 0);
    wr(2'd1, 8'h00);
    quiesce();
  endtask

  task automatic t_slow_late();
    int v, l;
    l = t_long(0, 0);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h05);
    cyc(l);
    check("R5 no fault at long", int'(irq), 0);
    cyc(1);
    check("R5 fault after long", int'(irq), 1);
    check("R9 irq mode no reset", int'(rst_out), 0);
    rd(2'd3, v);
    check("R8 status reads set", v, 1);
    wr(2'd3, 8'h00);
    check("R8 clear with bit0 low ignored", int'(irq), 1);
    wr(2'd3, 8'h01);
    check("R8 clear with bit0 high", int'(irq), 0);
    quiesce();
  endtask

  task automatic t_slow_feed();
    int l;
    l = t_long(0, 0);
    wr(2'd0, 8'h05);
    cyc(100);
    wr(2'd2, 8'h01);
    check("R6 slow early feed accepted", int'(irq), 0);
    cyc(l);
    check("R7 feed restarts count", int'(irq), 0);
    cyc(1);
    check("R7 fault relative to feed", int'(irq), 1);
    quiesce();
  endtask

  task automatic t_feed_bit0_low();
    int l;
    l = t_long(0, 0);
    wr(2'd0, 8'h05);
    cyc(100);
    wr(2'd2, 8'h02);
    cyc(l - 101);
    check("R7 ignored feed no fault yet", int'(irq), 0);
    cyc(1);
    check("R7 bit0 low feed had no effect", int'(irq), 1);
    quiesce();
  endtask

  task automatic t_window_early();
    int s;
    s = t_short(0);
    wr(2'd0, 8'h01);
    cyc(s - 1);
    check("R6 no fault before feed", int'(irq), 0);
    wr(2'd2, 8'h01);
    check("R6 early feed fault", int'(irq), 1);
    check("R9 irq mode no reset on early", int'(rst_out), 0);
    quiesce();
  endtask

  task automatic t_window_ok();
    int s;
    s = t_short(0);
    wr(2'd0, 8'h01);
    cyc(s);
    wr(2'd2, 8'h01);
    check("R6 feed at short accepted", int'(irq), 0);
    cyc(s);
    wr(2'd2, 8'h01);
    check("R6 second feed at short accepted", int'(irq), 0);
    quiesce();
  endtask

  task automatic t_reset_action();
    int l, hi, first;
    l = t_long(0, 0);
    wr(2'd0, 8'h09);
    cyc(l);
    check("R9 no pulse before fault", int'(rst_out), 0);
    hi = 0;
    first = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(1);
      if (i == 0) first = int'(rst_out);
      if (rst_out) hi++;
    end
    check("R9 pulse starts with fault", first, 1);
    check("R9 pulse length", hi, 16);
    check("R9 irq set in reset mode", int'(irq), 1);
    quiesce();
  endtask

  task automatic t_big_timeout();
    int v, s, l;
    s = t_short(1);
    l = t_long(1, 1);
    wr(2'd1, 8'h11);
    rd(2'd1, v);
    check("R2 tmo value held", v, 8'h11);
    wr(2'd0, 8'h05);
    cyc(l);
    check("R2 no fault at long sel1 ratio1", int'(irq), 0);
    cyc(1);
    check("R2 fault after long sel1 ratio1", int'(irq), 1);
    quiesce();
    wr(2'd0, 8'h01);
    cyc(s - 1);
    wr(2'd2, 8'h01);
    check("R2 short sel1 early feed fault", int'(irq), 1);
    quiesce();
    wr(2'd1, 8'h00);
  endtask

  task automatic t_disabled();
    int l;
    l = t_long(0, 0);
    wr(2'd0, 8'h06);
    cyc(l + 50);
    check("R3 mode 10 never faults", int'(irq), 0);
    wr(2'd2, 8'h01);
    check("R3 feed ignored in mode 10", int'(irq), 0);
    wr(2'd0, 8'h03);
    cyc(l + 50);
    check("R3 mode 11 never faults", int'(irq), 0);
    quiesce();
  endtask

  task automatic t_tick_gate();
    int l;
    l = t_long(0, 0);
    tick_us = 1'b0;
    wr(2'd0, 8'h05);
    cyc(l + 100);
    check("R4 no count without tick", int'(irq), 0);
    tick_us = 1'b1;
    cyc(l);
    check("R4 count resumes from zero", int'(irq), 0);
    cyc(1);
    check("R4 fault after ticks", int'(irq), 1);
    quiesce();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(2);
    t_reset_state();
    t_readback();
    t_slow_late();
    t_slow_feed();
    t_feed_bit0_low();
    t_window_early();
    t_window_ok();
    t_reset_action();
    t_big_timeout();
    t_disabled();
    t_tick_gate();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule